// File: doc/BRIEF.md
# Floating-Point Multi-Register Transfer Sequencer

This block turns one multi-register floating-point load or store into a stream of single-word micro-ops. On an accepted start pulse it captures a base register index, a first FP register index, a single/double selector, an up/down direction, a writeback request, a load/store selector and an 8-bit word-offset field. It then issues micro-ops one at a time over a valid/ready handshake. Each micro-op carries an opcode, the base register index, an FP register index, a direction bit, a non-negative byte displacement, a last flag and a delayed-commit flag.

Double-precision registers are split into two word transfers. A descending walk never issues a negative displacement: once its running address reaches zero or below, the walk becomes ascending on the negated address. A register count of zero, or one above 32, raises a sticky bad-count flag. A zero count still yields one micro-op, because writeback is forced on. A one-cycle done pulse marks the end of the stream.

Top module: `fpx_seq`

## Requirements
- R1: The register count is the offset field for singles and the offset field halved (rounded down) for doubles, clamped to 32. The stream holds count micro-ops for singles or 2×count for doubles, plus one when writeback is on.
- R2: bad_cnt_o is set by an accepted start when the unclamped count is 0 or above 32 and cleared by an accepted start otherwise. It holds its value at all other times.
- R3: A zero count forces the writeback micro-op on, even when wb_i is low.
- R4: Opcode encoding: 0 is FP load, 1 is FP store, 2 is add-immediate, 3 is subtract-immediate. Transfers come first, and the writeback micro-op, when present, comes last. Its opcode is 2 when up_i was high and 3 when it was low, and its displacement is 4×offset. uop_base_o carries the captured base index on every micro-op.
- R5: The running address starts at 0 when ascending and at 4×offset when descending. A double's second word uses the running address +4 when up_i was high and −4 when it was low. After each register the address moves by 4 (single) or 8 (double). A descending result of zero or below switches the walk to ascending and negates the address. No displacement is negative.
- R6: The FP register index starts at the captured first index and increments by one after every transfer micro-op, modulo 64. The writeback micro-op shows the index reached after the last transfer.
- R7: The final micro-op has uop_last_o high and uop_dcommit_o low. Every earlier micro-op has uop_last_o low and uop_dcommit_o high.
- R8: While uop_valid_o is high and uop_ready_i is low, the presented micro-op stays valid and unchanged.
- R9: A start pulse while a stream is in progress is ignored.
- R10: done_o is high for exactly the one cycle after the final micro-op is accepted, and uop_valid_o is low in that cycle.
- R11: During and after reset, uop_valid_o, done_o and bad_cnt_o are low. A reset in the middle of a stream ends it.
- R12: The direction bit of a transfer is the current walking direction. The direction bit of the writeback micro-op equals the captured up_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| base_i | input | 5 | Base register index |
| fp_first_i | input | 6 | First FP register index |
| dbl_i | input | 1 | 1 for double precision, 0 for single |
| up_i | input | 1 | 1 for an ascending walk, 0 for descending |
| wb_i | input | 1 | Writeback request |
| load_i | input | 1 | 1 for load, 0 for store |
| woff_i | input | 8 | Word-offset field |
| uop_ready_i | input | 1 | Consumer accepts the presented micro-op |
| uop_valid_o | output | 1 | Micro-op presented |
| uop_op_o | output | 2 | Opcode (encoding in R4) |
| uop_base_o | output | 5 | Base register index |
| uop_reg_o | output | 6 | FP register index |
| uop_up_o | output | 1 | Direction bit |
| uop_disp_o | output | 10 | Byte displacement |
| uop_last_o | output | 1 | Final micro-op of the stream |
| uop_dcommit_o | output | 1 | Delayed-commit marker |
| done_o | output | 1 | One-cycle pulse after the final acceptance |
| bad_cnt_o | output | 1 | Sticky bad-count flag |

## Verification
The assertions assume that start fields matter only in the cycle a start is accepted. uop_ready_i may toggle freely, and the consumer never needs a micro-op to be withdrawn. The stimulus keeps to this: it changes fields only at falling edges, uses three ready patterns (always ready, alternating, two of three), and pulses start again with inverted fields during a stream to show it is ignored. Offsets that round a double count to zero, clamp at the limit, or sit exactly on it are included, together with a reset applied mid-stream.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef enum logic [1:0] {
        FOP_LOAD  = 2'd0,
        FOP_STORE = 2'd1,
        FOP_ADDI  = 2'd2,
        FOP_SUBI  = 2'd3
    } fop_e;

endpackage

// File: rtl/fpx_cnt_decode.sv
module fpx_cnt_decode #(
    parameter int OFF_W = 8,
    parameter int LIMIT = 32,
    parameter int CNT_W = $clog2(LIMIT + 1),
    parameter int TOT_W = $clog2(2 * LIMIT + 2)
) (
    input  logic [OFF_W-1:0] woff_i,
    input  logic             dbl_i,
    input  logic             wb_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             bad_o,
    output logic             wb_eff_o,
    output logic [TOT_W-1:0] xfers_o,
    output logic [TOT_W-1:0] total_o
);

    logic [OFF_W-1:0] raw;
    logic             over;
    logic             zero;

    always_comb begin
        raw      = dbl_i ? (woff_i >> 1) : woff_i;
        over     = raw > OFF_W'(LIMIT);
        zero     = (raw == '0);
        bad_o    = over | zero;
        cnt_o    = over ? CNT_W'(LIMIT) : raw[CNT_W-1:0];
        wb_eff_o = wb_i | zero;
        xfers_o  = dbl_i ? (TOT_W'(cnt_o) << 1) : TOT_W'(cnt_o);
        total_o  = xfers_o + TOT_W'(wb_eff_o);
    end

endmodule

// File: rtl/fpx_addr_step.sv
module fpx_addr_step #(
    parameter int ADDR_W = 11
) (
    input  logic signed [ADDR_W-1:0] addr_i,
    input  logic                     wup_i,
    input  logic                     dir_i,
    input  logic                     dbl_i,
    input  logic                     half_i,
    output logic signed [ADDR_W-1:0] cur_o,
    output logic signed [ADDR_W-1:0] nxt_addr_o,
    output logic                     nxt_up_o
);

    localparam logic signed [ADDR_W-1:0] WORD_B = ADDR_W'(4);
    localparam logic signed [ADDR_W-1:0] DBL_B  = ADDR_W'(8);

    logic signed [ADDR_W-1:0] step;
    logic signed [ADDR_W-1:0] moved;

    always_comb begin
        // second word of a double sits one word beyond in the original direction
        if (half_i)
            cur_o = dir_i ? (addr_i + WORD_B) : (addr_i - WORD_B);
        else
            cur_o = addr_i;

        step  = dbl_i ? DBL_B : WORD_B;
        moved = wup_i ? (addr_i + step) : (addr_i - step);

        if (!wup_i && (moved[ADDR_W-1] || moved == '0)) begin
            nxt_up_o   = 1'b1;
            nxt_addr_o = -moved;
        end else begin
            nxt_up_o   = wup_i;
            nxt_addr_o = moved;
        end
    end

endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
    import fpx_pkg::*;
#(
    parameter int BASE_W = 5,
    parameter int REG_W  = 6,
    parameter int OFF_W  = 8,
    parameter int LIMIT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [REG_W-1:0]  fp_first_i,
    input  logic              dbl_i,
    input  logic              up_i,
    input  logic              wb_i,
    input  logic              load_i,
    input  logic [OFF_W-1:0]  woff_i,
    input  logic              uop_ready_i,
    output logic              uop_valid_o,
    output logic [1:0]        uop_op_o,
    output logic [BASE_W-1:0] uop_base_o,
    output logic [REG_W-1:0]  uop_reg_o,
    output logic              uop_up_o,
    output logic [OFF_W+1:0]  uop_disp_o,
    output logic              uop_last_o,
    output logic              uop_dcommit_o,
    output logic              done_o,
    output logic              bad_cnt_o
);

    localparam int DISP_W = OFF_W + 2;
    localparam int ADDR_W = DISP_W + 1;
    localparam int CNT_W  = $clog2(LIMIT + 1);
    localparam int TOT_W  = $clog2(2 * LIMIT + 2);

    typedef struct packed {
        logic                     busy;
        logic                     done;
        logic                     bad;
        logic [TOT_W-1:0]         idx;
        logic [TOT_W-1:0]         total;
        logic [TOT_W-1:0]         xfers;
        logic                     half;
        logic signed [ADDR_W-1:0] addr;
        logic                     wup;
        logic [REG_W-1:0]         freg;
        logic [BASE_W-1:0]        base;
        logic                     dbl;
        logic                     dir;
        logic                     ld;
        logic [OFF_W-1:0]         woff;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic [CNT_W-1:0]         dec_cnt;
    logic                     dec_bad;
    logic                     dec_wb;
    logic [TOT_W-1:0]         dec_xfers;
    logic [TOT_W-1:0]         dec_total;

    logic signed [ADDR_W-1:0] cur_addr;
    logic signed [ADDR_W-1:0] nxt_addr;
    logic                     nxt_up;

    logic                     fire;
    logic                     is_xfer;
    logic                     is_last;
    fop_e                     op_sel;

    fpx_cnt_decode #(
        .OFF_W (OFF_W),
        .LIMIT (LIMIT),
        .CNT_W (CNT_W),
        .TOT_W (TOT_W)
    ) u_dec (
        .woff_i   (woff_i),
        .dbl_i    (dbl_i),
        .wb_i     (wb_i),
        .cnt_o    (dec_cnt),
        .bad_o    (dec_bad),
        .wb_eff_o (dec_wb),
        .xfers_o  (dec_xfers),
        .total_o  (dec_total)
    );

    fpx_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_step (
        .addr_i     (s_q.addr),
        .wup_i      (s_q.wup),
        .dir_i      (s_q.dir),
        .dbl_i      (s_q.dbl),
        .half_i     (s_q.half),
        .cur_o      (cur_addr),
        .nxt_addr_o (nxt_addr),
        .nxt_up_o   (nxt_up)
    );

    always_comb begin
        fire    = s_q.busy & uop_ready_i;
        is_xfer = s_q.idx < s_q.xfers;
        is_last = s_q.idx == (s_q.total - TOT_W'(1));
        if (is_xfer)
            op_sel = s_q.ld ? FOP_LOAD : FOP_STORE;
        else
            op_sel = s_q.dir ? FOP_ADDI : FOP_SUBI;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy  = 1'b1;
                s_d.bad   = dec_bad;
                s_d.idx   = '0;
                s_d.total = dec_total;
                s_d.xfers = dec_xfers;
                s_d.half  = 1'b0;
                s_d.addr  = up_i ? '0 : ADDR_W'({woff_i, 2'b00});
                s_d.wup   = up_i;
                s_d.freg  = fp_first_i;
                s_d.base  = base_i;
                s_d.dbl   = dbl_i;
                s_d.dir   = up_i;
                s_d.ld    = load_i;
                s_d.woff  = woff_i;
            end
        end else if (fire) begin
            s_d.idx = s_q.idx + TOT_W'(1);
            if (is_xfer) begin
                s_d.freg = s_q.freg + REG_W'(1);
                if (s_q.dbl && !s_q.half) begin
                    s_d.half = 1'b1;
                end else begin
                    s_d.half = 1'b0;
                    s_d.addr = nxt_addr;
                    s_d.wup  = nxt_up;
                end
            end
            if (is_last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    always_comb begin
        uop_valid_o   = s_q.busy;
        uop_op_o      = op_sel;
        uop_base_o    = s_q.base;
        uop_reg_o     = s_q.freg;
        uop_up_o      = is_xfer ? s_q.wup : s_q.dir;
        uop_disp_o    = is_xfer ? cur_addr[DISP_W-1:0] : {s_q.woff, 2'b00};
        uop_last_o    = is_last;
        uop_dcommit_o = ~is_last;
        done_o        = s_q.done;
        bad_cnt_o     = s_q.bad;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_op_o) &&
        $stable(uop_disp_o) && $stable(uop_reg_o) && $stable(uop_last_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && uop_ready_i && uop_last_o) |=> (done_o && !uop_valid_o));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && !(uop_ready_i && uop_last_o)) |=> (uop_valid_o && $stable(uop_base_o)));

    // R2
    bad_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o || !start_i) |=> $stable(bad_cnt_o));

    // R5
    disp_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && (uop_op_o == FOP_LOAD || uop_op_o == FOP_STORE)) |-> !cur_addr[ADDR_W-1]);

    // R7
    not_last_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid_o && uop_ready_i && !uop_last_o) |=> uop_valid_o);

endmodule

// File: tb/fpx_seq_bench.sv
module fpx_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [4:0] base_i = '0;
    logic [5:0] fp_first_i = '0;
    logic       dbl_i = 1'b0;
    logic       up_i = 1'b0;
    logic       wb_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] woff_i = '0;
    logic       uop_ready_i = 1'b0;
    logic       uop_valid_o;
    logic [1:0] uop_op_o;
    logic [4:0] uop_base_o;
    logic [5:0] uop_reg_o;
    logic       uop_up_o;
    logic [9:0] uop_disp_o;
    logic       uop_last_o;
    logic       uop_dcommit_o;
    logic       done_o;
    logic       bad_cnt_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fpx_seq u_fpx_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .base_i        (base_i),
        .fp_first_i    (fp_first_i),
        .dbl_i         (dbl_i),
        .up_i          (up_i),
        .wb_i          (wb_i),
        .load_i        (load_i),
        .woff_i        (woff_i),
        .uop_ready_i   (uop_ready_i),
        .uop_valid_o   (uop_valid_o),
        .uop_op_o      (uop_op_o),
        .uop_base_o    (uop_base_o),
        .uop_reg_o     (uop_reg_o),
        .uop_up_o      (uop_up_o),
        .uop_disp_o    (uop_disp_o),
        .uop_last_o    (uop_last_o),
        .uop_dcommit_o (uop_dcommit_o),
        .done_o        (done_o),
        .bad_cnt_o     (bad_cnt_o)
    );

    // vector: {dbl, up, wb, load, woff[7:0], fp_first[5:0], ready pattern[1:0]}
    localparam int NVEC = 11;
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd3,   6'd2,  2'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd4,   6'd7,  2'd1},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'd4,   6'd10, 2'd2},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'd6,   6'd0,  2'd0},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'd5,   6'd3,  2'd1},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd1,   6'd63, 2'd0},
        {1'b0, 1'b1, 1'b0, 1'b1, 8'd0,   6'd5,  2'd2},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd1,   6'd9,  2'd0},
        {1'b0, 1'b1, 1'b1, 1'b1, 8'd40,  6'd1,  2'd1},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd100, 6'd40, 2'd2},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'd32,  6'd20, 2'd0}
    };

    int e_op   [0:79];
    int e_reg  [0:79];
    int e_disp [0:79];
    int e_up   [0:79];
    int e_total;
    int e_bad;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // expected stream built from R1, R3, R4, R5, R6, R12
    task automatic build_exp(input bit dbl, input bit up, input bit wb, input bit ld,
                             input int woff, input int fps);
        int cnt;
        int addr;
        bit tup;
        bit wbe;
        int n;
        int r;
        cnt   = dbl ? woff / 2 : woff;
        e_bad = (cnt == 0 || cnt > 32) ? 1 : 0;
        wbe   = wb || (cnt == 0);
        if (cnt > 32) cnt = 32;
        addr = up ? 0 : 4 * woff;
        tup  = up;
        n    = 0;
        r    = fps;
        for (int j = 0; j < cnt; j++) begin
            e_op[n] = ld ? 0 : 1; e_reg[n] = r % 64; e_disp[n] = addr; e_up[n] = tup;
            n++; r++;
            if (dbl) begin
                e_op[n] = ld ? 0 : 1; e_reg[n] = r % 64;
                e_disp[n] = addr + (up ? 4 : -4); e_up[n] = tup;
                n++; r++;
            end
            if (!tup) begin
                addr -= dbl ? 8 : 4;
                if (addr <= 0) begin
                    tup  = 1'b1;
                    addr = -addr;
                end
            end else begin
                addr += dbl ? 8 : 4;
            end
        end
        if (wbe) begin
            e_op[n] = up ? 2 : 3; e_reg[n] = r % 64; e_disp[n] = 4 * woff; e_up[n] = up;
            n++;
        end
        e_total = n;
    endtask

    task automatic run_case(input logic [19:0] v, input bit inject);
        bit         dbl;
        bit         up;
        bit         wb;
        bit         ld;
        int         woff;
        int         fps;
        int         pat;
        int         k;
        int         cyc;
        logic [4:0] base;
        dbl  = v[19]; up = v[18]; wb = v[17]; ld = v[16];
        woff = int'(v[15:8]); fps = int'(v[7:2]); pat = int'(v[1:0]);
        base = v[6:2] ^ 5'h15;
        build_exp(dbl, up, wb, ld, woff, fps);

        @(negedge clk);
        uop_ready_i = 1'b0;
        start_i = 1'b1; dbl_i = dbl; up_i = up; wb_i = wb; load_i = ld;
        woff_i = v[15:8]; fp_first_i = v[7:2]; base_i = base;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R2", "bad flag after start", int'(bad_cnt_o), e_bad);
        chk("R11", "valid after start", int'(uop_valid_o), 1);
        @(negedge clk);

        k   = 0;
        cyc = 0;
        while (k < e_total && cyc < 400) begin
            case (pat)
                1:       uop_ready_i = cyc[0];
                2:       uop_ready_i = (cyc % 3) != 0;
                default: uop_ready_i = 1'b1;
            endcase
            if (inject && cyc == 2) begin
                start_i = 1'b1; dbl_i = ~dbl; up_i = ~up; wb_i = 1'b1; load_i = ~ld;
                woff_i = 8'd9; fp_first_i = 6'd33; base_i = ~base;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (!uop_valid_o) begin
                chk("R8", "valid during stream", 0, 1);
                k = e_total;
            end else if (uop_ready_i) begin
                chk("R4", "opcode", int'(uop_op_o), e_op[k]);
                chk("R4", "base index", int'(uop_base_o), int'(base));
                chk("R6", "fp register", int'(uop_reg_o), e_reg[k]);
                chk("R5", "displacement", int'(uop_disp_o), e_disp[k]);
                chk("R12", "direction bit", int'(uop_up_o), e_up[k]);
                chk("R7", "last flag", int'(uop_last_o), (k == e_total - 1) ? 1 : 0);
                chk("R7", "delayed commit", int'(uop_dcommit_o), (k == e_total - 1) ? 0 : 1);
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        chk("R1", "micro-op total reached", k, e_total);
        uop_ready_i = 1'b0;
        start_i = 1'b0;
        #1;
        chk("R10", "done pulse", int'(done_o), 1);
        chk("R10", "valid low at done", int'(uop_valid_o), 0);
        @(negedge clk);
        #1;
        chk("R10", "done drops", int'(done_o), 0);
        chk("R9", "no extra stream", int'(uop_valid_o), 0);
        chk("R2", "bad flag sticky", int'(bad_cnt_o), e_bad);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        chk("R11", "valid in reset", int'(uop_valid_o), 0);
        chk("R11", "done in reset", int'(done_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "valid after reset", int'(uop_valid_o), 0);
        chk("R11", "bad after reset", int'(bad_cnt_o), 0);

        for (int i = 0; i < NVEC; i++)
            run_case(VEC[i], 1'b0);

        // R9: start pulsed with other fields mid-stream
        run_case({1'b0, 1'b1, 1'b1, 1'b0, 8'd5, 6'd12, 2'd1}, 1'b1);
        run_case({1'b1, 1'b0, 1'b1, 1'b1, 8'd8, 6'd30, 2'd0}, 1'b1);

        // R3: zero double count with writeback low gives a lone subtract
        run_case({1'b1, 1'b0, 1'b0, 1'b1, 8'd1, 6'd4, 2'd1}, 1'b0);

        // R2: a good start clears the flag left by the bad case above
        run_case({1'b0, 1'b1, 1'b0, 1'b1, 8'd2, 6'd0, 2'd0}, 1'b0);

        // R11: reset in the middle of a stream
        @(negedge clk);
        start_i = 1'b1; dbl_i = 1'b0; up_i = 1'b1; wb_i = 1'b0; load_i = 1'b1;
        woff_i = 8'd0; fp_first_i = 6'd0;
        @(negedge clk);
        start_i = 1'b0;
        uop_ready_i = 1'b0;
        #1;
        chk("R2", "bad set before reset", int'(bad_cnt_o), 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11", "valid cleared by reset", int'(uop_valid_o), 0);
        chk("R11", "bad cleared by reset", int'(bad_cnt_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "idle after reset", int'(uop_valid_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule